// File: doc/BRIEF.md
# SPI Transfer Word Buffer

This block sits between a 32-bit register bus and an SPI shift engine. It holds two queues of 32-bit words. Software writes words into the transmit queue, and the engine takes them from the head one at a time. Received bytes from the engine are packed four to a receive word, whatever the configured serial word length. When a frame ends early, the partial word is still stored. A byte count kept with each receive word tells software how many of its bytes are real.

Each direction has a control register with a queue enable, a flush command and a trigger level. One request line per direction is driven from the fill level and the trigger level. A status register shows both fill levels, the byte count of the receive word at the head, and two sticky error flags. An identification register reports both queue depths, so software can size its bursts without knowing the build parameters.

Top module: `spi_xfer_buffer`

## Requirements
- R1: The register at byte offset 0x00 is read-only. It reads the transmit depth in bits [29:24] and the receive depth in bits [21:16]; all other bits read 0.
- R2: After reset, both queues are empty, both control registers read 0, the status register (offset 0x04) reads 0, eng_tx_valid is low, irq_rx is low and irq_tx is high.
- R3: Words written to offset 0x10 leave the transmit side in write order. eng_tx_valid is high while the queue holds a word, eng_tx_data shows the oldest word, and a cycle with eng_tx_take high removes that word.
- R4: Every four received bytes form one receive word, with the first byte in bits [31:24] and the last byte in bits [7:0]. That word has a byte count of 4.
- R5: When eng_rx_end is high and 1 to 3 bytes are pending, counting a byte given in the same cycle, they form a word with the last byte in bits [7:0], the first byte in the highest valid lane, zeros above, and a byte count of 1 to 3. An end with no pending bytes stores nothing. Status bits [30:28] show the byte count of the head word, or 0 when the receive queue is empty. A read of offset 0x14 returns the head word and removes it.
- R6: Status bits [5:0] give the receive fill level and bits [13:8] the transmit fill level.
- R7: The transmit control register is at 0x08 and the receive control register at 0x0C. In each, bit 0 is the enable and bits [13:8] the trigger level. While the enable is 0 the queue holds at most one word; while it is 1 it holds its full depth.
- R8: Writing 1 to bit 1 of a control register empties that queue by the next cycle, together with any receive bytes not yet packed in the receive case. The other queue is left alone, and the bit always reads back 0.
- R9: irq_rx is high while the receive level is non-zero and at or above its trigger level. irq_tx is high while the transmit level is at or below its trigger level.
- R10: A transmit write while the transmit queue is full is dropped and sets status bit 16. A receive read while the receive queue is empty returns 0 and sets status bit 17. A packed word arriving at a full receive queue is dropped.
- R11: Status bits 16 and 17 stay set until software writes 1 to that bit at offset 0x04. Writing 0 there leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| eng_tx_valid | output | 1 | Transmit queue holds a word |
| eng_tx_data | output | 32 | Oldest transmit word |
| eng_tx_take | input | 1 | Engine consumes the oldest transmit word |
| eng_rx_vld | input | 1 | Engine delivers one received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_end | input | 1 | Frame end: store any partial word |
| irq_tx | output | 1 | Transmit request from the level and trigger |
| irq_rx | output | 1 | Receive request from the level and trigger |

## Verification
Receive packing is tried with frames of six, one and three bytes, and with a frame end that has no bytes pending. These show full-word lane order apart from right alignment of a partial word, and from the byte counts 4, 2, 1 and 3. Flushing with two bytes pending, followed by a clean four-byte group, shows whether the packer is really cleared. Both queues are run disabled and enabled, and filled past capacity, to separate the one-word limit from the full depth and to show that drops leave the stored order intact. Trigger levels of 2 and 3 are stepped one word at a time, to show the opposite compare direction of the two request lines.

// File: rtl/spibuf_pkg.sv
package spibuf_pkg;

    // Width of one queue entry and of the bus data path
    localparam int DATA_W   = 32;
    localparam int LANES    = DATA_W / 8;
    localparam int CNT_W    = $clog2(LANES);
    localparam int BV_W     = $clog2(LANES + 1);
    localparam int FIELD_W  = 6;

    // Word indices of the registers (byte offset / 4)
    localparam int IDX_ID    = 0;
    localparam int IDX_STAT  = 1;
    localparam int IDX_TXCTL = 2;
    localparam int IDX_RXCTL = 3;
    localparam int IDX_TXDAT = 4;
    localparam int IDX_RXDAT = 5;

    // Control register field positions
    localparam int CTL_EN_BIT    = 0;
    localparam int CTL_FLUSH_BIT = 1;
    localparam int CTL_TRIG_LSB  = 8;

    // Status and identification field positions
    localparam int ST_RXLVL_LSB = 0;
    localparam int ST_TXLVL_LSB = 8;
    localparam int ST_TXOVF_BIT = 16;
    localparam int ST_RXUNF_BIT = 17;
    localparam int ST_BV_LSB    = 28;
    localparam int ID_TXD_LSB   = 24;
    localparam int ID_RXD_LSB   = 16;

    // One receive entry: packed bytes plus how many of them are valid
    typedef struct packed {
        logic [BV_W-1:0]   bv;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    // Stored per-direction configuration
    typedef struct packed {
        logic               en;
        logic [FIELD_W-1:0] trig;
    } dir_cfg_t;

endpackage

// File: rtl/spibuf_fifo.sv
// Synchronous single-clock queue with a selectable capacity.
// Assumes: DEPTH >= 1. Push is refused when full, pop is ignored when empty.
// flush empties the queue and takes priority over push and pop in the same cycle.
// With wide_en low the capacity is one entry; with it high the capacity is DEPTH.
module spibuf_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wide_en,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] cap;
    logic             do_push, do_pop;

    // Capacity in force and the accepted operations
    always_comb begin
        cap     = wide_en ? LVL_W'(DEPTH) : LVL_W'(1);
        full    = (level >= cap);
        empty   = (level == '0);
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        dout    = mem[rd_ptr];
    end

    // Storage write, no reset needed on the data array
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointer and level bookkeeping with wrap at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                level <= level + 1'b1;
            end else if (do_pop && !do_push) begin
                level <= level - 1'b1;
            end
        end
    end

endmodule

// File: rtl/spibuf_rx_packer.sv
// Packs received bytes into receive entries, first byte in the highest valid lane.
// Assumes: at most one byte per cycle. An entry is emitted in the same cycle as
// the byte that completes it, or on frame end when bytes are pending.
// flush drops any pending bytes.
module spibuf_rx_packer
    import spibuf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        byte_vld,
    input  logic [7:0]  byte_in,
    input  logic        frame_end,
    output logic        push,
    output rx_entry_t   entry
);
    localparam int ACC_W = DATA_W - 8;

    logic [ACC_W-1:0] acc;
    logic [CNT_W-1:0] cnt;
    logic [BV_W-1:0]  nxt_cnt;
    logic [DATA_W-1:0] nxt_word;

    // Next packed word and byte count including this cycle's byte
    always_comb begin
        nxt_cnt    = BV_W'(cnt) + BV_W'(byte_vld);
        nxt_word   = byte_vld ? {acc, byte_in} : {8'h00, acc};
        push       = (nxt_cnt == BV_W'(LANES)) || (frame_end && (nxt_cnt != '0));
        entry.data = nxt_word;
        entry.bv   = nxt_cnt;
    end

    // Accumulator: cleared on emit or flush, shifted left by one byte otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || flush || push) begin
            acc <= '0;
            cnt <= '0;
        end else if (byte_vld) begin
            acc <= nxt_word[ACC_W-1:0];
            cnt <= nxt_cnt[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/spibuf_dir_ctl.sv
// Per-direction control: enable, trigger level, flush strobe and request line.
// Assumes: LVL_W <= 6. RX_SIDE selects the compare: receive requests at or above
// the trigger (and non-empty), transmit requests at or below it.
module spibuf_dir_ctl
    import spibuf_pkg::*;
#(
    parameter bit RX_SIDE = 1'b0,
    parameter int LVL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic               wr_en_bit,
    input  logic               wr_flush_bit,
    input  logic [FIELD_W-1:0] wr_trig,
    input  logic [LVL_W-1:0]   level,
    output dir_cfg_t           cfg,
    output logic               flush,
    output logic               irq
);
    logic [FIELD_W-1:0] lvl6;

    // Stored enable and trigger, updated on a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_stb) begin
            cfg.en   <= wr_en_bit;
            cfg.trig <= wr_trig;
        end
    end

    // Flush is a pulse in the write cycle only; nothing is stored
    assign flush = wr_stb && wr_flush_bit;
    assign lvl6  = FIELD_W'(level);

    // Request compare picked by direction
    generate
        if (RX_SIDE) begin : g_rx_req
            assign irq = (lvl6 != '0) && (lvl6 >= cfg.trig);
        end else begin : g_tx_req
            assign irq = (lvl6 <= cfg.trig);
        end
    endgenerate

endmodule

// File: rtl/spi_xfer_buffer.sv
// Register-mapped transmit and receive word queues for an SPI shift engine.
// Assumes: single-cycle bus strobes, word-aligned byte addresses, depths 1..63.
// Reads are combinational; a receive data read removes the head word at the edge.
module spi_xfer_buffer
    import spibuf_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 6,
    parameter int ADDR_W   = 5,
    localparam int TX_LW   = $clog2(TX_DEPTH + 1),
    localparam int RX_LW   = $clog2(RX_DEPTH + 1),
    localparam int IDX_W   = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              eng_tx_valid,
    output logic [31:0]       eng_tx_data,
    input  logic              eng_tx_take,
    input  logic              eng_rx_vld,
    input  logic [7:0]        eng_rx_byte,
    input  logic              eng_rx_end,
    output logic              irq_tx,
    output logic              irq_rx
);
    logic [IDX_W-1:0] widx;
    logic             hit;
    logic             wr_stat, wr_txctl, wr_rxctl, wr_txdat, rd_rxdat;
    logic             tx_flush, rx_flush;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [TX_LW-1:0] tx_lvl;
    logic [RX_LW-1:0] rx_lvl;
    dir_cfg_t         tx_cfg, rx_cfg;
    rx_entry_t        pk_entry, rx_head;
    logic             pk_push;
    logic             tx_ovf, rx_unf;
    logic             tx_ovf_clr, rx_unf_clr;
    logic [BV_W-1:0]  head_bv;
    logic [31:0]      id_word, stat_word, txctl_word, rxctl_word;

    // Address decode into one-cycle register strobes
    always_comb begin
        widx     = bus_addr[ADDR_W-1:2];
        hit      = bus_sel && (bus_addr[1:0] == 2'b00);
        wr_stat  = hit && bus_wr  && (widx == IDX_W'(IDX_STAT));
        wr_txctl = hit && bus_wr  && (widx == IDX_W'(IDX_TXCTL));
        wr_rxctl = hit && bus_wr  && (widx == IDX_W'(IDX_RXCTL));
        wr_txdat = hit && bus_wr  && (widx == IDX_W'(IDX_TXDAT));
        rd_rxdat = hit && !bus_wr && (widx == IDX_W'(IDX_RXDAT));
        tx_ovf_clr = wr_stat && bus_wdata[ST_TXOVF_BIT];
        rx_unf_clr = wr_stat && bus_wdata[ST_RXUNF_BIT];
    end

    spibuf_dir_ctl #(.RX_SIDE(1'b0), .LVL_W(TX_LW)) u_txctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_stb       (wr_txctl),
        .wr_en_bit    (bus_wdata[CTL_EN_BIT]),
        .wr_flush_bit (bus_wdata[CTL_FLUSH_BIT]),
        .wr_trig      (bus_wdata[CTL_TRIG_LSB +: FIELD_W]),
        .level        (tx_lvl),
        .cfg          (tx_cfg),
        .flush        (tx_flush),
        .irq          (irq_tx)
    );

    spibuf_dir_ctl #(.RX_SIDE(1'b1), .LVL_W(RX_LW)) u_rxctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_stb       (wr_rxctl),
        .wr_en_bit    (bus_wdata[CTL_EN_BIT]),
        .wr_flush_bit (bus_wdata[CTL_FLUSH_BIT]),
        .wr_trig      (bus_wdata[CTL_TRIG_LSB +: FIELD_W]),
        .level        (rx_lvl),
        .cfg          (rx_cfg),
        .flush        (rx_flush),
        .irq          (irq_rx)
    );

    spibuf_fifo #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (tx_flush),
        .wide_en (tx_cfg.en),
        .push    (wr_txdat),
        .din     (bus_wdata),
        .pop     (eng_tx_take),
        .dout    (eng_tx_data),
        .level   (tx_lvl),
        .full    (tx_full),
        .empty   (tx_empty)
    );

    spibuf_rx_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .byte_vld  (eng_rx_vld),
        .byte_in   (eng_rx_byte),
        .frame_end (eng_rx_end),
        .push      (pk_push),
        .entry     (pk_entry)
    );

    spibuf_fifo #(.W($bits(rx_entry_t)), .DEPTH(RX_DEPTH)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (rx_flush),
        .wide_en (rx_cfg.en),
        .push    (pk_push),
        .din     (pk_entry),
        .pop     (rd_rxdat),
        .dout    (rx_head),
        .level   (rx_lvl),
        .full    (rx_full),
        .empty   (rx_empty)
    );

    assign eng_tx_valid = !tx_empty;

    // Sticky error flags: set by the offending access, cleared by write-one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_ovf <= 1'b0;
            rx_unf <= 1'b0;
        end else begin
            if (wr_txdat && tx_full) begin
                tx_ovf <= 1'b1;
            end else if (tx_ovf_clr) begin
                tx_ovf <= 1'b0;
            end
            if (rd_rxdat && rx_empty) begin
                rx_unf <= 1'b1;
            end else if (rx_unf_clr) begin
                rx_unf <= 1'b0;
            end
        end
    end

    // Assemble the readable register words
    always_comb begin
        head_bv   = rx_empty ? '0 : rx_head.bv;
        id_word   = '0;
        id_word[ID_TXD_LSB +: FIELD_W] = FIELD_W'(TX_DEPTH);
        id_word[ID_RXD_LSB +: FIELD_W] = FIELD_W'(RX_DEPTH);
        stat_word = '0;
        stat_word[ST_RXLVL_LSB +: FIELD_W] = FIELD_W'(rx_lvl);
        stat_word[ST_TXLVL_LSB +: FIELD_W] = FIELD_W'(tx_lvl);
        stat_word[ST_TXOVF_BIT] = tx_ovf;
        stat_word[ST_RXUNF_BIT] = rx_unf;
        stat_word[ST_BV_LSB +: BV_W] = head_bv;
        txctl_word = '0;
        txctl_word[CTL_EN_BIT] = tx_cfg.en;
        txctl_word[CTL_TRIG_LSB +: FIELD_W] = tx_cfg.trig;
        rxctl_word = '0;
        rxctl_word[CTL_EN_BIT] = rx_cfg.en;
        rxctl_word[CTL_TRIG_LSB +: FIELD_W] = rx_cfg.trig;
    end

    // Read data mux, zero for unmapped or misaligned addresses
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[1:0] == 2'b00) begin
            if (widx == IDX_W'(IDX_ID))         bus_rdata = id_word;
            else if (widx == IDX_W'(IDX_STAT))  bus_rdata = stat_word;
            else if (widx == IDX_W'(IDX_TXCTL)) bus_rdata = txctl_word;
            else if (widx == IDX_W'(IDX_RXCTL)) bus_rdata = rxctl_word;
            else if (widx == IDX_W'(IDX_RXDAT)) bus_rdata = rx_empty ? '0 : rx_head.data;
        end
    end

endmodule

// File: rtl/spibuf_chk.sv
// Property checker for spi_xfer_buffer, attached by bind below.
// Assumes: observes internal queue levels and strobes of the bound instance.
module spibuf_chk
    import spibuf_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 6,
    localparam int TX_LW   = $clog2(TX_DEPTH + 1),
    localparam int RX_LW   = $clog2(RX_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TX_LW-1:0] tx_lvl,
    input logic [RX_LW-1:0] rx_lvl,
    input logic             tx_flush,
    input logic             rx_flush,
    input logic             wr_txdat,
    input logic             rd_rxdat,
    input logic             tx_full,
    input logic             rx_full,
    input logic             pk_push,
    input logic             eng_tx_take,
    input logic             tx_ovf,
    input logic             rx_unf,
    input logic             tx_ovf_clr,
    input logic             irq_rx,
    input rx_entry_t        rx_head
);

    // R7
    tx_level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tx_lvl) <= TX_DEPTH);

    // R7
    rx_level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rx_lvl) <= RX_DEPTH);

    // R8
    tx_flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> (tx_lvl == '0));

    // R8
    rx_flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (rx_lvl == '0));

    // R10
    tx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_txdat && tx_full && !eng_tx_take && !tx_flush) |=> $stable(tx_lvl));

    // R10
    rx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_push && rx_full && !rd_rxdat && !rx_flush) |=> $stable(rx_lvl));

    // R10
    rx_unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxdat && rx_lvl == '0) |=> rx_unf);

    // R11
    tx_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovf && !tx_ovf_clr) |=> tx_ovf);

    // R5
    head_bv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_lvl != '0) |-> (rx_head.bv >= 3'd1 && rx_head.bv <= 3'd4));

    // R9
    rx_req_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> (rx_lvl != '0));

endmodule

bind spi_xfer_buffer spibuf_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_lvl      (tx_lvl),
    .rx_lvl      (rx_lvl),
    .tx_flush    (tx_flush),
    .rx_flush    (rx_flush),
    .wr_txdat    (wr_txdat),
    .rd_rxdat    (rd_rxdat),
    .tx_full     (tx_full),
    .rx_full     (rx_full),
    .pk_push     (pk_push),
    .eng_tx_take (eng_tx_take),
    .tx_ovf      (tx_ovf),
    .rx_unf      (rx_unf),
    .tx_ovf_clr  (tx_ovf_clr),
    .irq_rx      (irq_rx),
    .rx_head     (rx_head)
);

// File: tb/sim_spi_xfer_buffer.sv
module sim_spi_xfer_buffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_tx_valid;
    logic [31:0] eng_tx_data;
    logic        eng_tx_take = 1'b0;
    logic        eng_rx_vld = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        eng_rx_end = 1'b0;
    logic        irq_tx, irq_rx;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    localparam logic [4:0] A_ID = 5'h00, A_ST = 5'h04, A_TXC = 5'h08,
                           A_RXC = 5'h0C, A_TXD = 5'h10, A_RXD = 5'h14;

    spi_xfer_buffer u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
        .eng_tx_take(eng_tx_take), .eng_rx_vld(eng_rx_vld),
        .eng_rx_byte(eng_rx_byte), .eng_rx_end(eng_rx_end),
        .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] st(int rxl, int txl, int bv, bit ovf, bit unf);
        logic [31:0] v = '0;
        v[5:0]   = 6'(rxl);
        v[13:8]  = 6'(txl);
        v[16]    = ovf;
        v[17]    = unf;
        v[30:28] = 3'(bv);
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic rx_byte(input logic [7:0] b, input bit last);
        @(negedge clk);
        eng_rx_vld = 1'b1; eng_rx_byte = b; eng_rx_end = last;
        @(posedge clk); #1;
        eng_rx_vld = 1'b0; eng_rx_end = 1'b0;
    endtask

    task automatic rx_end_only();
        @(negedge clk);
        eng_rx_end = 1'b1;
        @(posedge clk); #1;
        eng_rx_end = 1'b0;
    endtask

    task automatic tx_take();
        @(negedge clk);
        eng_tx_take = 1'b1;
        @(posedge clk); #1;
        eng_tx_take = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 id", A_ID, 32'h0806_0000);
        rd_chk("R2 status", A_ST, 32'h0);
        rd_chk("R2 txctl", A_TXC, 32'h0);
        rd_chk("R2 rxctl", A_RXC, 32'h0);
        chk("R2 tx valid", {31'b0, eng_tx_valid}, 32'd0);
        chk("R2 irq_tx", {31'b0, irq_tx}, 32'd1);
        chk("R2 irq_rx", {31'b0, irq_rx}, 32'd0);
        wr(A_ID, 32'hFFFF_FFFF);
        rd_chk("R1 id read-only", A_ID, 32'h0806_0000);
    endtask

    task automatic t_tx_disabled();
        wr(A_TXD, 32'hAAAA_0001);
        wr(A_TXD, 32'hAAAA_0002);
        rd_chk("R7 R10 one-word cap", A_ST, st(0, 1, 0, 1, 0));
        chk("R7 head kept", eng_tx_data, 32'hAAAA_0001);
        wr(A_ST, 32'h0);
        rd_chk("R11 zero write keeps flag", A_ST, st(0, 1, 0, 1, 0));
        wr(A_ST, 32'h0001_0000);
        rd_chk("R11 clear ovf", A_ST, st(0, 1, 0, 0, 0));
        wr(A_TXC, 32'h2);
        rd_chk("R8 tx flush", A_ST, 32'h0);
        rd_chk("R8 flush reads 0", A_TXC, 32'h0);
    endtask

    task automatic t_tx_order();
        wr(A_TXC, 32'h0000_0301);
        for (int i = 0; i < 4; i++) wr(A_TXD, 32'h1000_0000 + i);
        rd_chk("R6 tx level", A_ST, st(0, 4, 0, 0, 0));
        chk("R9 irq_tx above trig", {31'b0, irq_tx}, 32'd0);
        chk("R3 valid", {31'b0, eng_tx_valid}, 32'd1);
        chk("R3 head0", eng_tx_data, 32'h1000_0000);
        tx_take();
        chk("R3 head1", eng_tx_data, 32'h1000_0001);
        chk("R9 irq_tx at trig", {31'b0, irq_tx}, 32'd1);
        tx_take();
        chk("R3 head2", eng_tx_data, 32'h1000_0002);
        tx_take();
        chk("R3 head3", eng_tx_data, 32'h1000_0003);
        tx_take();
        chk("R3 drained", {31'b0, eng_tx_valid}, 32'd0);
    endtask

    task automatic t_tx_full();
        for (int i = 0; i < 9; i++) wr(A_TXD, 32'h2000_0000 + i);
        rd_chk("R10 full drop", A_ST, st(0, 8, 0, 1, 0));
        chk("R10 head intact", eng_tx_data, 32'h2000_0000);
        wr(A_TXC, 32'h0000_0303);
        rd_chk("R8 R11 flush keeps flag", A_ST, st(0, 0, 0, 1, 0));
        rd_chk("R8 ctl after flush", A_TXC, 32'h0000_0301);
        wr(A_ST, 32'h0001_0000);
    endtask

    task automatic t_rx_pack();
        wr(A_RXC, 32'h1);
        rx_byte(8'h11, 0); rx_byte(8'h22, 0); rx_byte(8'h33, 0);
        rx_byte(8'h44, 0); rx_byte(8'h55, 0); rx_byte(8'h66, 1);
        rd_chk("R5 R6 status bv4", A_ST, st(2, 0, 4, 0, 0));
        rd_chk("R4 full word", A_RXD, 32'h1122_3344);
        rd_chk("R5 status bv2", A_ST, st(1, 0, 2, 0, 0));
        rd_chk("R5 two-byte word", A_RXD, 32'h0000_5566);
        rd_chk("R5 empty bv0", A_ST, 32'h0);
        rx_byte(8'h77, 1);
        rd_chk("R5 bv1", A_ST, st(1, 0, 1, 0, 0));
        rd_chk("R5 one-byte word", A_RXD, 32'h0000_0077);
        rx_byte(8'h88, 0); rx_byte(8'h99, 0); rx_byte(8'hAA, 1);
        rd_chk("R5 bv3", A_ST, st(1, 0, 3, 0, 0));
        rd_chk("R5 three-byte word", A_RXD, 32'h0088_99AA);
        rx_end_only();
        rd_chk("R5 bare end stores nothing", A_ST, 32'h0);
    endtask

    task automatic t_rx_irq();
        wr(A_RXC, 32'h0000_0201);
        for (int i = 0; i < 4; i++) rx_byte(8'(8'h40 + i), 0);
        chk("R9 irq_rx below trig", {31'b0, irq_rx}, 32'd0);
        for (int i = 0; i < 4; i++) rx_byte(8'(8'h50 + i), 0);
        chk("R9 irq_rx at trig", {31'b0, irq_rx}, 32'd1);
        rd_chk("R4 first word", A_RXD, 32'h4041_4243);
        chk("R9 irq_rx drops", {31'b0, irq_rx}, 32'd0);
        rd_chk("R4 second word", A_RXD, 32'h5051_5253);
    endtask

    task automatic t_rx_unf();
        rd_chk("R10 empty read", A_RXD, 32'h0);
        rd_chk("R10 unf flag", A_ST, st(0, 0, 0, 0, 1));
        wr(A_ST, 32'h0002_0000);
        rd_chk("R11 clear unf", A_ST, 32'h0);
    endtask

    task automatic t_rx_flush();
        wr(A_TXD, 32'hCAFE_0001);
        rx_byte(8'hC1, 0); rx_byte(8'hC2, 0);
        wr(A_RXC, 32'h3);
        rd_chk("R8 rx flush, tx untouched", A_ST, st(0, 1, 0, 0, 0));
        rx_byte(8'hD1, 0); rx_byte(8'hD2, 0); rx_byte(8'hD3, 0); rx_byte(8'hD4, 0);
        rd_chk("R8 partial bytes discarded", A_RXD, 32'hD1D2_D3D4);
        wr(A_TXC, 32'h2);
    endtask

    task automatic t_rx_cap();
        wr(A_RXC, 32'h0);
        for (int i = 0; i < 8; i++) rx_byte(8'(8'hE0 + i), 0);
        rd_chk("R7 rx one-word cap", A_ST, st(1, 0, 4, 0, 0));
        rd_chk("R7 rx kept first", A_RXD, 32'hE0E1_E2E3);
        wr(A_RXC, 32'h1);
        for (int i = 0; i < 28; i++) rx_byte(8'(i), 0);
        rd_chk("R10 rx full drop", A_ST, st(6, 0, 4, 0, 0));
        rd_chk("R10 rx order kept", A_RXD, 32'h0001_0203);
        wr(A_RXC, 32'h3);
        rd_chk("R8 rx flush full", A_ST, 32'h0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx_disabled();
        t_tx_order();
        t_tx_full();
        t_rx_pack();
        t_rx_irq();
        t_rx_unf();
        t_rx_flush();
        t_rx_cap();
        finish_run();
    end

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule